// File: doc/BRIEF.md
# Burst-Counted SPI Master Exchange Engine

This block runs full-duplex SPI exchanges as the bus master. Software loads a burst length and a transmit length, pushes bytes into a transmit queue and sets a start bit. The engine then clocks out exactly the burst number of bytes. The first bytes come from the transmit queue and the rest are zero. Every byte shifted in lands in a receive queue, unless the control word asks for received data to be thrown away. Both queues hold 128 bytes.

The serial clock rate is set outside the block. A strobe input marks each moment at which SCLK may toggle, so one bit takes two strobes. Four chip-select lines are driven from a 2-bit index. The engine can drive the selected line by itself while it is busy, or software can set its level directly. At the end of a burst the engine raises a sticky completion flag. A second sticky flag records receive overflow. Each flag can drive the interrupt line, and software clears a flag by writing 1 to it.

Top module: `spi_burst_master`

## Requirements
- R1: Writing the control register (address 0) with bit 31 set, while idle, exchanges exactly the number of bytes in the burst register (address 4, 24 bits). That is 8 leading SCLK edges per byte. A burst of 0 completes without any SCLK edge.
- R2: Of the burst bytes, the first N are taken from the TX queue in push order, where N is the transmit-count register (address 5, 24 bits). All later bytes go out as 0x00.
- R3: If the TX queue is empty when a byte is due from it, 0x00 is sent instead. The burst does not stall, and that byte still counts against N.
- R4: Control bit 1 (CPOL) sets the idle SCLK level. Control bit 0 (CPHA) = 0 samples MISO on the leading edge and changes MOSI on the trailing edge. CPHA = 1 does the reverse. The received bytes must match what the slave sent in all four modes.
- R5: Control bit 12 = 1 sends and receives each byte LSB first. When it is 0, each byte goes MSB first.
- R6: Control bits 5:4 select one of four chip-select lines. Bit 2 = 1 makes the idle level high and the active level low. With bit 6 = 0, the selected line is active only while busy. With bit 6 = 1, the selected line follows bit 7. Unselected lines stay idle. At most one line is ever non-idle.
- R7: With control bit 8 set, received bytes are dropped and the RX fill count stays 0.
- R8: Each queue holds 128 bytes. A push into a full TX queue is dropped. The fill output shows the RX count in bits 7:0 and the TX count in bits 23:16.
- R9: Writing 1 to bit 15 of the queue-control register (address 3) empties the RX queue. Writing 1 to bit 31 of it empties the TX queue.
- R10: At the end of a burst, status bit 12 is set. The status register is at address 2, and writing 1 to a bit clears it. If a clear and a set fall in the same cycle, the set wins. irq_o is high when a status bit is set and the matching bit of the enable register (address 1) is set.
- R11: When a received byte finds the RX queue full, the byte is dropped and status bit 8 is set.
- R12: Bit 31 of the control register clears itself when the burst ends. Control-register writes made while busy are ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| tx_push_i | input | 1 | Push one byte into the TX queue |
| tx_byte_i | input | 8 | Byte to push |
| rx_pop_i | input | 1 | Pop the head of the RX queue |
| rx_byte_o | output | 8 | Head of the RX queue |
| ctl_o | output | 32 | Control register readback |
| stat_o | output | 32 | Status flags (bit 12 done, bit 8 overflow) |
| fill_o | output | 32 | Queue fill counts |
| sclk_tick_i | input | 1 | SCLK toggle strobe from the external divider |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| irq_o | output | 1 | Interrupt |

## Verification
The completion flag can be set by the engine in the same cycle that software writes 1 to clear it. To force this collision, the bench holds a write-1-to-clear of bit 12 asserted on every cycle of a burst, up to and including the cycle in which the burst ends. It releases the write only after it sees the start bit drop. The flag must then read as set, since a lost completion would leave software waiting forever. The bench also pushes more bytes than the transmit count allows, and fewer than it needs, so that reading from the queue and substituting zeros both appear inside one burst.

// File: rtl/spi_bm_pkg.sv
// Shared register map, bit positions and helpers for the burst SPI master.
// Assumes bytes are 8 bits wide.
package spi_bm_pkg;
    localparam logic [2:0] RA_CTL   = 3'd0;
    localparam logic [2:0] RA_IEN   = 3'd1;
    localparam logic [2:0] RA_STAT  = 3'd2;
    localparam logic [2:0] RA_FCTL  = 3'd3;
    localparam logic [2:0] RA_BURST = 3'd4;
    localparam logic [2:0] RA_TXCNT = 3'd5;

    localparam int CB_CPHA    = 0;
    localparam int CB_CPOL    = 1;
    localparam int CB_CSPOL   = 2;
    localparam int CB_SEL     = 4;
    localparam int CB_MANUAL  = 6;
    localparam int CB_LEVEL   = 7;
    localparam int CB_DISCARD = 8;
    localparam int CB_LSB     = 12;
    localparam int CB_START   = 31;

    localparam int SB_OVF = 8;
    localparam int SB_TC  = 12;

    localparam int FB_RXCLR = 15;
    localparam int FB_TXCLR = 31;

    // Return bit k of a byte in transmission order
    function automatic logic bit_pick(logic [7:0] b, logic [2:0] k, logic lsb);
        return lsb ? b[k] : b[3'd7 - k];
    endfunction
endpackage

// File: rtl/spi_bm_fifo.sv
// Byte queue with show-ahead head, fill count and synchronous clear.
// Assumes DEPTH is a power of two. A push into a full queue is dropped
// unless a pop happens in the same cycle; drop_o flags the lost push.
module spi_bm_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          drop_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          pop_ok, push_ok;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign pop_ok  = pop_i && !empty_o;
    assign push_ok = push_i && (!full_o || pop_ok);
    assign drop_o  = push_i && !push_ok && !clr_i;
    assign head_o  = mem[rd_q];
    assign count_o = cnt_q;

    // Storage write, no reset needed for data
    always_ff @(posedge clk) begin
        if (push_ok && !clr_i) mem[wr_q] <= data_i;
    end

    // Pointer and count update, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + AW'(1);
            if (pop_ok)  rd_q <= rd_q + AW'(1);
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
        end
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clr_i) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/spi_bm_shifter.sv
// Serializes one byte per load in any CPOL/CPHA mode and bit order.
// Each tick_i toggles SCLK; one byte takes 16 ticks. done_o pulses one
// cycle after the last toggle, with rx_o already holding the full byte.
// Assumes load_i is only raised while the shifter is not active.
module spi_bm_shifter
    import spi_bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       cpol_i,
    input  logic       cpha_i,
    input  logic       lsb_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o,
    output logic       active_o
);
    logic       active_q, sclk_q, mosi_q, done_q;
    logic [3:0] half_q;
    logic [7:0] tx_q, rx_q;
    logic [2:0] bit_idx;
    logic       lead, sample_now;

    assign bit_idx    = half_q[3:1];
    assign lead       = ~half_q[0];
    assign sample_now = active_q && tick_i && !load_i && (lead ^ cpha_i);

    // Edge sequencing, SCLK and MOSI generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            half_q   <= '0;
            tx_q     <= '0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                active_q <= 1'b1;
                half_q   <= '0;
                tx_q     <= byte_i;
                sclk_q   <= cpol_i;
                mosi_q   <= bit_pick(byte_i, 3'd0, lsb_i);
            end else if (active_q && tick_i) begin
                sclk_q <= ~sclk_q;
                half_q <= half_q + 4'd1;
                if (lead && cpha_i)
                    mosi_q <= bit_pick(tx_q, bit_idx, lsb_i);
                if (!lead && !cpha_i && half_q != 4'd15)
                    mosi_q <= bit_pick(tx_q, 3'(bit_idx + 3'd1), lsb_i);
                if (half_q == 4'd15) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end else if (!active_q) begin
                sclk_q <= cpol_i;
            end
        end
    end

    // MISO capture on the sampling edge
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_q <= '0;
        else if (sample_now) rx_q[lsb_i ? bit_idx : 3'd7 - bit_idx] <= miso_i;
    end

    assign sclk_o   = sclk_q;
    assign mosi_o   = mosi_q;
    assign done_o   = done_q;
    assign rx_o     = rx_q;
    assign active_o = active_q;

    // R4
    byte_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (sclk_q == cpol_i));
    // R1
    done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(active_q));
endmodule

// File: rtl/spi_bm_csel.sv
// Drives the chip-select lines from the index, polarity, manual mode and
// level fields. Only the selected line can leave its idle level.
module spi_bm_csel #(
    parameter int NCS    = 4,
    localparam int SEL_W = $clog2(NCS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             idle_high_i,
    input  logic             manual_i,
    input  logic             level_i,
    input  logic             busy_i,
    output logic [NCS-1:0]   cs_o
);
    // Per-line level selection
    for (genvar i = 0; i < NCS; i++) begin : g_line
        always_comb begin
            if (sel_i != SEL_W'(i))
                cs_o[i] = idle_high_i;
            else if (manual_i)
                cs_o[i] = level_i;
            else
                cs_o[i] = busy_i ? ~idle_high_i : idle_high_i;
        end
    end

    // R6
    single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o ^ {NCS{idle_high_i}}));
endmodule

// File: rtl/spi_burst_master.sv
// Burst-counted SPI master. Register writes configure and start a burst.
// The engine fetches bytes from the TX queue (or zero), shifts them via
// the shifter, stores received bytes, and raises sticky status flags.
// Assumes sclk_tick_i comes from an external divider, one strobe per half bit.
module spi_burst_master
    import spi_bm_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int CNT_W  = 24,
    parameter int NCS    = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int SEL_W = $clog2(NCS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr_i,
    input  logic [2:0]     reg_addr_i,
    input  logic [31:0]    reg_wdata_i,
    input  logic           tx_push_i,
    input  logic [7:0]     tx_byte_i,
    input  logic           rx_pop_i,
    output logic [7:0]     rx_byte_o,
    output logic [31:0]    ctl_o,
    output logic [31:0]    stat_o,
    output logic [31:0]    fill_o,
    input  logic           sclk_tick_i,
    output logic           sclk_o,
    output logic           mosi_o,
    input  logic           miso_i,
    output logic [NCS-1:0] cs_o,
    output logic           irq_o
);
    logic [31:0]    ctl_q, ien_q;
    logic [CNT_W-1:0] burst_q, txc_q, burst_left, tx_left;
    logic           stat_tc, stat_ovf, need_q;
    logic           busy, load, finish, tx_avail;
    logic           wr_ctl, wr_ien, wr_stat, wr_fctl, wr_burst, wr_txc;
    logic           tx_clr, rx_clr, tx_pop, rx_push, rx_drop;
    logic [7:0]     tx_head, load_byte, sh_rx;
    logic [CW-1:0]  tx_cnt, rx_cnt;
    logic           tx_full, tx_empty, tx_drop, rx_full, rx_empty;
    logic           sh_done, sh_active;

    assign busy     = ctl_q[CB_START];
    assign wr_ctl   = reg_wr_i && reg_addr_i == RA_CTL;
    assign wr_ien   = reg_wr_i && reg_addr_i == RA_IEN;
    assign wr_stat  = reg_wr_i && reg_addr_i == RA_STAT;
    assign wr_fctl  = reg_wr_i && reg_addr_i == RA_FCTL;
    assign wr_burst = reg_wr_i && reg_addr_i == RA_BURST;
    assign wr_txc   = reg_wr_i && reg_addr_i == RA_TXCNT;
    assign tx_clr   = wr_fctl && reg_wdata_i[FB_TXCLR];
    assign rx_clr   = wr_fctl && reg_wdata_i[FB_RXCLR];

    // Byte sourcing: queue head while the transmit count lasts and data exists
    assign load      = busy && need_q && (burst_left != '0);
    assign finish    = busy && need_q && (burst_left == '0);
    assign tx_avail  = (tx_left != '0) && !tx_empty;
    assign tx_pop    = load && tx_avail;
    assign load_byte = tx_avail ? tx_head : 8'h00;
    assign rx_push   = sh_done && !ctl_q[CB_DISCARD];

    // Configuration, counters and engine sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ien_q      <= '0;
            burst_q    <= '0;
            txc_q      <= '0;
            burst_left <= '0;
            tx_left    <= '0;
            need_q     <= 1'b0;
        end else begin
            if (wr_ctl && !busy) begin
                ctl_q <= reg_wdata_i;
                if (reg_wdata_i[CB_START]) begin
                    burst_left <= burst_q;
                    tx_left    <= txc_q;
                    need_q     <= 1'b1;
                end
            end
            if (wr_ien) begin
                ien_q <= '0;
                ien_q[SB_TC]  <= reg_wdata_i[SB_TC];
                ien_q[SB_OVF] <= reg_wdata_i[SB_OVF];
            end
            if (wr_burst) burst_q <= reg_wdata_i[CNT_W-1:0];
            if (wr_txc)   txc_q   <= reg_wdata_i[CNT_W-1:0];
            if (finish) begin
                ctl_q[CB_START] <= 1'b0;
                need_q          <= 1'b0;
            end
            if (load) begin
                need_q     <= 1'b0;
                burst_left <= burst_left - CNT_W'(1);
                if (tx_left != '0) tx_left <= tx_left - CNT_W'(1);
            end
            if (busy && sh_done) need_q <= 1'b1;
        end
    end

    // Sticky status flags: write-1 clears, a same-cycle set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_tc  <= 1'b0;
            stat_ovf <= 1'b0;
        end else begin
            if (wr_stat && reg_wdata_i[SB_TC])  stat_tc  <= 1'b0;
            if (wr_stat && reg_wdata_i[SB_OVF]) stat_ovf <= 1'b0;
            if (finish)  stat_tc  <= 1'b1;
            if (rx_drop) stat_ovf <= 1'b1;
        end
    end

    // Readback assembly
    always_comb begin
        stat_o = '0;
        stat_o[SB_TC]  = stat_tc;
        stat_o[SB_OVF] = stat_ovf;
        fill_o = '0;
        fill_o[CW-1:0]  = rx_cnt;
        fill_o[16 +: CW] = tx_cnt;
    end

    assign ctl_o = ctl_q;
    assign irq_o = (stat_tc && ien_q[SB_TC]) || (stat_ovf && ien_q[SB_OVF]);

    spi_bm_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr_i(tx_clr),
        .push_i(tx_push_i), .data_i(tx_byte_i), .pop_i(tx_pop),
        .head_o(tx_head), .count_o(tx_cnt), .full_o(tx_full),
        .empty_o(tx_empty), .drop_o(tx_drop)
    );

    spi_bm_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr_i(rx_clr),
        .push_i(rx_push), .data_i(sh_rx), .pop_i(rx_pop_i),
        .head_o(rx_byte_o), .count_o(rx_cnt), .full_o(rx_full),
        .empty_o(rx_empty), .drop_o(rx_drop)
    );

    spi_bm_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tick_i(sclk_tick_i), .load_i(load),
        .byte_i(load_byte), .cpol_i(ctl_q[CB_CPOL]), .cpha_i(ctl_q[CB_CPHA]),
        .lsb_i(ctl_q[CB_LSB]), .miso_i(miso_i), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .done_o(sh_done), .rx_o(sh_rx), .active_o(sh_active)
    );

    spi_bm_csel #(.NCS(NCS)) u_cs (
        .clk(clk), .rst_n(rst_n), .sel_i(ctl_q[CB_SEL +: SEL_W]),
        .idle_high_i(ctl_q[CB_CSPOL]), .manual_i(ctl_q[CB_MANUAL]),
        .level_i(ctl_q[CB_LEVEL]), .busy_i(busy), .cs_o(cs_o)
    );

    // R10
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q[CB_START]) |-> stat_tc);
    // R7
    discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q[CB_DISCARD] && !rx_clr) |=> (rx_cnt <= $past(rx_cnt)));
    // R12
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctl) |=> (ctl_q[30:0] == $past(ctl_q[30:0])));
    // R3
    no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && need_q && burst_left != '0) |=> sh_active);
    // R11
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop_i && !rx_clr) |=> stat_ovf);
endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_byte;
    logic [31:0] ctl, stat, fill;
    logic        tick = 1'b0;
    logic        sclk, mosi, irq;
    logic        miso = 1'b0;
    logic [3:0]  cs;

    int n_chk = 0;
    int n_err = 0;
    int tdiv = 0;

    logic [7:0] txq [256];
    logic [7:0] mi  [256];
    logic [7:0] got [256];
    int  mon_n, drv_n, lead_cnt, cur_burst;
    bit  mon_en = 0;
    logic m_cpol = 0, m_cpha = 0, m_lsb = 0;
    logic sclk_prev = 0;

    always #5 clk = ~clk;

    spi_burst_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .tx_push_i(tx_push), .tx_byte_i(tx_byte),
        .rx_pop_i(rx_pop), .rx_byte_o(rx_byte), .ctl_o(ctl), .stat_o(stat),
        .fill_o(fill), .sclk_tick_i(tick), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso), .cs_o(cs), .irq_o(irq)
    );

    // Divider stand-in: one strobe every fourth cycle
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    function automatic logic mbit(int n);
        if (n / 8 >= cur_burst) return 1'b0;
        return m_lsb ? mi[n / 8][n % 8] : mi[n / 8][7 - n % 8];
    endfunction

    // Slave model: capture MOSI on sampling edges, drive MISO on the others
    always @(negedge clk) begin
        if (mon_en && sclk !== sclk_prev) begin
            if (sclk !== m_cpol) lead_cnt++;
            if ((sclk !== m_cpol) ^ m_cpha) begin
                if (mon_n / 8 < 256)
                    got[mon_n / 8][m_lsb ? mon_n % 8 : 7 - mon_n % 8] = mosi;
                mon_n++;
            end else if (m_cpha) begin
                miso = mbit(drv_n);
                drv_n++;
            end else begin
                drv_n++;
                miso = mbit(drv_n);
            end
        end
        sclk_prev = sclk;
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk);
        tx_push = 1'b1; tx_byte = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk);
        b = rx_byte;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    // One full burst with expected values built from the requirements
    task automatic do_xfer(logic cpol, logic cpha, logic lsb, logic disc,
                           int burst, int txc, int npush, bit poke);
        logic [31:0] cfg;
        logic [7:0]  b;
        int bad, first, nrx;
        wr(3'd3, 32'h8000_8000);
        wr(3'd2, 32'h0000_1100);
        for (int i = 0; i < npush; i++) begin
            txq[i] = 8'($urandom);
            push(txq[i]);
        end
        for (int i = 0; i < 256; i++) begin
            mi[i]  = (i < burst) ? 8'($urandom) : 8'h00;
            got[i] = 8'h00;
        end
        wr(3'd4, 32'(burst));
        wr(3'd5, 32'(txc));
        cfg = 32'(cpha) | (32'(cpol) << 1) | (32'(disc) << 8) | (32'(lsb) << 12);
        if (poke) cfg = cfg | 32'h34;
        wr(3'd0, cfg);
        repeat (2) @(negedge clk);
        chk(sclk == cpol, "R4 idle sclk level", 32'(sclk), 32'(cpol));
        m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; cur_burst = burst;
        mon_n = 0; drv_n = 0; lead_cnt = 0;
        miso = mbit(0);
        mon_en = 1;
        wr(3'd0, cfg | 32'h8000_0000);
        if (poke) begin
            repeat (30) @(negedge clk);
            chk(cs == 4'b0111, "R6 auto select active low", 32'(cs), 32'h7);
            wr(3'd0, (cfg ^ 32'h2) | 32'h8000_0000);
            chk(ctl == (cfg | 32'h8000_0000), "R12 write while busy ignored", ctl, cfg | 32'h8000_0000);
        end
        while (ctl[31]) @(negedge clk);
        repeat (3) @(negedge clk);
        mon_en = 0;
        chk(lead_cnt == 8 * burst, "R1 leading edge count", lead_cnt, 8 * burst);
        bad = 0; first = 0;
        for (int i = 0; i < burst; i++) begin
            logic [7:0] e;
            e = (i < txc && i < npush) ? txq[i] : 8'h00;
            if (got[i] !== e && bad == 0) first = i;
            if (got[i] !== e) bad++;
        end
        chk(bad == 0, "R2 R3 R5 MOSI bytes", 32'(got[first]),
            32'((first < txc && first < npush) ? txq[first] : 8'h00));
        chk(stat[12] == 1'b1, "R10 done flag", 32'(stat[12]), 1);
        chk(ctl[31] == 1'b0, "R12 start self-clear", 32'(ctl[31]), 0);
        if (poke) chk(cs == 4'b1111, "R6 idle after burst", 32'(cs), 32'hf);
        nrx = disc ? 0 : ((burst > 128) ? 128 : burst);
        chk(fill[7:0] == 8'(nrx), "R7 R8 RX fill", 32'(fill[7:0]), nrx);
        if (!disc)
            chk(stat[8] == (burst > 128), "R11 overflow flag", 32'(stat[8]), 32'(burst > 128));
        if (burst <= 128) begin
            bad = 0;
            for (int i = 0; i < nrx; i++) begin
                pop(b);
                if (b !== mi[i]) bad++;
            end
            chk(bad == 0, "R4 R5 received bytes", bad, 0);
        end
    endtask

    initial begin
        logic [7:0] b;
        void'($urandom(32'd20240));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl == 0 && stat == 0 && fill == 0, "R12 R10 R8 reset state", ctl | stat | fill, 0);
        chk(cs == 4'b0000 && irq == 0 && sclk == 0, "R6 reset pins", 32'(cs), 0);

        do_xfer(0, 0, 0, 0, 4, 4, 4, 0);
        do_xfer(1, 1, 1, 0, 6, 3, 3, 0);
        do_xfer(0, 1, 0, 0, 5, 5, 2, 0);
        chk(fill[23:16] == 0, "R3 TX queue drained", 32'(fill[23:16]), 0);
        do_xfer(1, 0, 0, 1, 3, 3, 3, 0);
        do_xfer(0, 0, 0, 0, 0, 0, 0, 0);
        do_xfer(1, 1, 0, 0, 4, 4, 4, 1);
        for (int it = 0; it < 8; it++) begin
            int bu, tc, np;
            bu = 1 + int'($urandom % 10);
            tc = int'($urandom % (bu + 1));
            np = int'($urandom % (tc + 3));
            do_xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                    bu, tc, np, 0);
        end

        // Overflow and RX clear
        do_xfer(0, 1, 1, 0, 130, 0, 0, 0);
        chk(irq == 0, "R10 irq masked", 32'(irq), 0);
        wr(3'd1, 32'h0000_0100);
        chk(irq == 1, "R11 overflow irq", 32'(irq), 1);
        wr(3'd2, 32'h0000_0100);
        chk(stat[8] == 0 && stat[12] == 1, "R11 overflow W1C", stat, 32'h1000);
        wr(3'd3, 32'h0000_8000);
        chk(fill[7:0] == 0, "R9 RX clear", 32'(fill[7:0]), 0);

        // TX queue depth, drop on full, clear
        for (int i = 0; i < 130; i++) push(8'(i));
        chk(fill[23:16] == 8'd128, "R8 TX depth", 32'(fill[23:16]), 128);
        wr(3'd3, 32'h8000_0000);
        chk(fill[23:16] == 0, "R9 TX clear", 32'(fill[23:16]), 0);

        // Completion set colliding with a write-1-to-clear
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h1100);
        wr(3'd4, 32'd2);
        wr(3'd5, 32'd0);
        wr(3'd0, 32'h8000_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1000;
        while (ctl[31]) @(negedge clk);
        reg_wr = 1'b0;
        chk(stat[12] == 1, "R10 set wins over clear", 32'(stat[12]), 1);
        wr(3'd1, 32'h0000_1000);
        chk(irq == 1, "R10 irq enabled", 32'(irq), 1);
        wr(3'd2, 32'h0000_1000);
        chk(irq == 0 && stat[12] == 0, "R10 W1C clears", 32'(irq), 0);

        // Manual chip select
        wr(3'd0, 32'h0000_00E0);
        chk(cs == 4'b0100, "R6 manual high on line 2", 32'(cs), 32'h4);
        wr(3'd0, 32'h0000_0054);
        chk(cs == 4'b1101, "R6 manual low on line 1", 32'(cs), 32'hd);

        pop(b);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule